// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Line Status

This block turns an asynchronous serial line into bytes. The line idles high, and each character is framed by one start bit, eight data bits sent least significant bit first, an optional even or odd parity bit and one stop bit. The block samples the line on a 16x baud tick and writes each finished character into a 16-entry receive queue. Every entry carries three error tags of its own: parity, framing and break.

The status byte is read at the same time as the queue head. It shows the tags of the character at the head of the queue, not those of the last character received. It also shows a sticky overrun flag and two transmitter flags that come in from outside. Pulsing the status-read strobe clears the sticky and tag bits. Pulsing the queue-read strobe moves on to the next character.

Top module: `serial_rx_status`

## Requirements
- R1: Status bit 0 (data ready) is 1 exactly while the receive queue holds at least one unread character, and it is 0 after reset. Characters leave the queue in arrival order on `rxData`, data bit 0 being the first bit after the start bit.
- R2: When a character completes while the queue already holds 16 entries, status bit 1 (overrun) goes to 1. The new character is discarded and the queued characters are left unchanged.
- R3: When parity is enabled (`parityEn`=1), a character whose parity bit does not match the setting is tagged with a parity error. `parityOdd`=0 selects even parity and 1 selects odd. The tag appears in status bit 2.
- R4: A character whose sampled stop bit is 0 is tagged with a framing error, which appears in status bit 3.
- R5: After a framing error, the low stop-bit sample is taken as the mid-point of a new start bit. The eight line bit-times that follow are received as the next character.
- R6: A line held low for a whole character time gives one queue entry: data 0x00, break tag set (status bit 4) and framing tag set. No further character is accepted until the line has gone high again.
- R7: Status bits 2 to 4 show the tags of the character at the queue head, and they are 0 when the queue is empty.
- R8: A status-read pulse clears status bits 1 to 4 from the next cycle on. The head's tags show again once the queue advances. Bits 1 to 4 are 0 after reset.
- R9: Status bit 5 follows `thrEmpty` one cycle later, and bit 6 is 1 only when `thrEmpty` and `tsrEmpty` are both 1. Both bits reset to 1, and bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxIn | input | 1 | Serial receive line, idle high |
| baudTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| parityEn | input | 1 | 1 = frame carries a parity bit |
| parityOdd | input | 1 | 0 = even parity, 1 = odd parity |
| fifoRd | input | 1 | Pop the queue head |
| rxData | output | 8 | Data of the queue head, 0 when empty |
| statusRd | input | 1 | Status read strobe, clears bits 1 to 4 |
| status | output | 8 | Line status byte |
| thrEmpty | input | 1 | Transmit holding register is empty |
| tsrEmpty | input | 1 | Transmit shift register is empty |

## Verification
Two situations are the hardest to reach from the pins: a queue that is full at the moment a seventeenth character completes, and a head whose tags differ from those of the latest character. For both, the bench turns off its reading monitor, so characters pile up. It then inspects the status byte by hand before it lets the scoreboard drain the queue. The framing-error resynchronisation is reached by driving the next character's data bits straight after a low stop bit, with no new start bit in between.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SRX_DATA_W = 8;

  // strobes from the bit-timing control to the datapath
  typedef struct packed {
    logic bitVal;
    logic sampleData;
    logic sampleParity;
    logic push;
    logic tagFrame;
    logic tagBreak;
  } srx_strobe_t;

  typedef struct packed {
    logic                  brk;
    logic                  frm;
    logic                  par;
    logic [SRX_DATA_W-1:0] data;
  } srx_entry_t;
endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxIn,
  input  logic        baudTick,
  input  logic        parityEn,
  output srx_strobe_t stb
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(SRX_DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SRX_DATA_W - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP, ST_BRKWAIT
  } rx_state_t;

  logic rxS;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= rxIn;
      assign rxS = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxIn};
      assign rxS = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  rx_state_t        state, stateNx;
  logic [CNT_W-1:0] tickCnt, tickCntNx;
  logic [IDX_W-1:0] bitIdx, bitIdxNx;
  logic             sawOne, sawOneNx;

  always_comb begin
    stateNx   = state;
    tickCntNx = tickCnt;
    bitIdxNx  = bitIdx;
    sawOneNx  = sawOne;
    stb       = '0;
    stb.bitVal = rxS;
    case (state)
      ST_IDLE: begin
        if (baudTick && !rxS) begin
          stateNx   = ST_START;
          tickCntNx = '0;
        end
      end
      ST_START: begin
        if (baudTick) begin
          if (tickCnt == MID_CNT) begin
            tickCntNx = '0;
            bitIdxNx  = '0;
            sawOneNx  = 1'b0;
            stateNx   = rxS ? ST_IDLE : ST_DATA;
          end else begin
            tickCntNx = tickCnt + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (baudTick) begin
          if (tickCnt == LAST_CNT) begin
            stb.sampleData = 1'b1;
            tickCntNx      = '0;
            sawOneNx       = sawOne | rxS;
            if (bitIdx == LAST_IDX) stateNx = parityEn ? ST_PARITY : ST_STOP;
            else                    bitIdxNx = bitIdx + 1'b1;
          end else begin
            tickCntNx = tickCnt + 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (baudTick) begin
          if (tickCnt == LAST_CNT) begin
            stb.sampleParity = 1'b1;
            tickCntNx        = '0;
            sawOneNx         = sawOne | rxS;
            stateNx          = ST_STOP;
          end else begin
            tickCntNx = tickCnt + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (baudTick) begin
          if (tickCnt == LAST_CNT) begin
            stb.push  = 1'b1;
            tickCntNx = '0;
            if (rxS) begin
              stateNx = ST_IDLE;
            end else if (!sawOne) begin
              stb.tagFrame = 1'b1;
              stb.tagBreak = 1'b1;
              stateNx      = ST_BRKWAIT;
            end else begin
              // low stop sample taken as the middle of a new start bit
              stb.tagFrame = 1'b1;
              bitIdxNx     = '0;
              sawOneNx     = 1'b0;
              stateNx      = ST_DATA;
            end
          end else begin
            tickCntNx = tickCnt + 1'b1;
          end
        end
      end
      ST_BRKWAIT: begin
        if (rxS) stateNx = ST_IDLE;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      sawOne  <= 1'b0;
    end else begin
      state   <= stateNx;
      tickCnt <= tickCntNx;
      bitIdx  <= bitIdxNx;
      sawOne  <= sawOneNx;
    end
  end
endmodule

// File: rtl/srx_datapath.sv
module srx_datapath
  import srx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  srx_strobe_t           stb,
  input  logic                  parityEn,
  input  logic                  parityOdd,
  input  logic                  fifoRd,
  input  logic                  statusRd,
  input  logic                  thrEmpty,
  input  logic                  tsrEmpty,
  output logic [SRX_DATA_W-1:0] rxData,
  output logic [7:0]            status,
  output logic                  fifoFull
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam logic [PTR_W:0] FULL_LVL = (PTR_W + 1)'(FIFO_DEPTH);

  logic [SRX_DATA_W-1:0] shiftReg;
  logic                  parBit;
  logic                  parErr;
  srx_entry_t            newEntry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (stb.sampleData)   shiftReg <= {stb.bitVal, shiftReg[SRX_DATA_W-1:1]};
      if (stb.sampleParity) parBit   <= stb.bitVal;
    end
  end

  assign parErr = parityEn && ((^shiftReg ^ parBit) != parityOdd);

  always_comb begin
    newEntry.brk  = stb.tagBreak;
    newEntry.frm  = stb.tagFrame;
    newEntry.par  = parErr && !stb.tagBreak;
    newEntry.data = stb.tagBreak ? '0 : shiftReg;
  end

  srx_entry_t     mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PTR_W:0]   level;
  logic             empty, doPush, doPop;

  assign empty    = (level == '0);
  assign fifoFull = (level == FULL_LVL);
  assign doPush   = stb.push && !fifoFull;
  assign doPop    = fifoRd && !empty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  srx_entry_t head;
  assign head   = mem[rdPtr];
  assign rxData = empty ? '0 : head.data;

  logic overrun, tagMask, thrQ, temtQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrun <= 1'b0;
      tagMask <= 1'b0;
      thrQ    <= 1'b1;
      temtQ   <= 1'b1;
    end else begin
      if (stb.push && fifoFull) overrun <= 1'b1;
      else if (statusRd)        overrun <= 1'b0;
      if (doPop || (doPush && empty)) tagMask <= 1'b0;
      else if (statusRd)              tagMask <= 1'b1;
      thrQ  <= thrEmpty;
      temtQ <= thrEmpty && tsrEmpty;
    end
  end

  logic showTags;
  assign showTags = !empty && !tagMask;

  always_comb begin
    status    = '0;
    status[0] = !empty;
    status[1] = overrun;
    status[2] = showTags && head.par;
    status[3] = showTags && head.frm;
    status[4] = showTags && head.brk;
    status[5] = thrQ;
    status[6] = temtQ;
  end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import srx_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rxIn,
  input  logic                  baudTick,
  input  logic                  parityEn,
  input  logic                  parityOdd,
  input  logic                  fifoRd,
  output logic [SRX_DATA_W-1:0] rxData,
  input  logic                  statusRd,
  output logic [7:0]            status,
  input  logic                  thrEmpty,
  input  logic                  tsrEmpty
);
  srx_strobe_t stb;
  logic        fifoFull;
  logic        pushStb;

  assign pushStb = stb.push;

  srx_ctrl #(
    .OVERSAMPLE (OVERSAMPLE),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxIn    (rxIn),
    .baudTick(baudTick),
    .parityEn(parityEn),
    .stb     (stb)
  );

  srx_datapath #(
    .FIFO_DEPTH(FIFO_DEPTH)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .parityEn (parityEn),
    .parityOdd(parityOdd),
    .fifoRd   (fifoRd),
    .statusRd (statusRd),
    .thrEmpty (thrEmpty),
    .tsrEmpty (tsrEmpty),
    .rxData   (rxData),
    .status   (status),
    .fifoFull (fifoFull)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] status,
  input logic [7:0] rxData,
  input logic       statusRd,
  input logic       fifoRd,
  input logic       thrEmpty,
  input logic       pushStb,
  input logic       fifoFull
);
  AST_READY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (pushStb && !fifoFull) |=> status[0]); // R1

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (pushStb && fifoFull) |=> status[1]); // R2

  AST_FULL_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    (pushStb && fifoFull && !fifoRd) |=> $stable(rxData)); // R2

  AST_NO_TAGS_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !status[0] |-> (status[4:2] == 3'b000)); // R7

  AST_READ_CLEARS_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !(pushStb && fifoFull)) |=> !status[1]); // R8

  AST_THRE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (status[5] == $past(thrEmpty))); // R9
endmodule

bind serial_rx_status srx_checker uChk (
  .clk     (clk),
  .rstN    (rstN),
  .status  (status),
  .rxData  (rxData),
  .statusRd(statusRd),
  .fifoRd  (fifoRd),
  .thrEmpty(thrEmpty),
  .pushStb (pushStb),
  .fifoFull(fifoFull)
);

// File: tb/tb_serial_rx_status.sv
`timescale 1ns/1ps
module tb_serial_rx_status;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxIn = 1'b1;
  logic       baudTick = 1'b0;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       fifoRd = 1'b0;
  logic       statusRd = 1'b0;
  logic       thrEmpty = 1'b1;
  logic       tsrEmpty = 1'b1;
  logic [7:0] rxData;
  logic [7:0] status;

  int checks = 0;
  int failures = 0;
  bit monOn = 1'b0;
  string curReq = "R1";
  logic [10:0] expQ[$];

  always #10 clk = ~clk;

  serial_rx_status dut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .baudTick(baudTick),
    .parityEn(parityEn), .parityOdd(parityOdd), .fifoRd(fifoRd),
    .rxData(rxData), .statusRd(statusRd), .status(status),
    .thrEmpty(thrEmpty), .tsrEmpty(tsrEmpty)
  );

  int tickCnt = 0;
  always @(negedge clk) begin
    tickCnt  <= (tickCnt == TICK_DIV - 1) ? 0 : tickCnt + 1;
    baudTick <= (tickCnt == TICK_DIV - 1);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as characters reach the queue head
  initial begin
    forever begin
      @(negedge clk);
      if (monOn && status[0]) begin
        logic [10:0] obs;
        obs = {status[4:2], rxData};
        if (expQ.size() == 0) begin
          check(1'b0, curReq, obs, 11'h0);
        end else begin
          logic [10:0] exp;
          exp = expQ.pop_front();
          check(obs == exp, curReq, obs, exp);
        end
        fifoRd = 1'b1; statusRd = 1'b1;
        @(negedge clk);
        fifoRd = 1'b0; statusRd = 1'b0;
      end
    end
  end

  task automatic sendBit(input logic b);
    rxIn = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendData(input logic [7:0] d);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
  endtask

  function automatic logic goodPar(input logic [7:0] d);
    return ^d ^ parityOdd;
  endfunction

  // start, data, optional parity, stop, one idle bit
  task automatic sendFrame(input logic [7:0] d, input bit badPar);
    sendBit(1'b0);
    sendData(d);
    if (parityEn) sendBit(goodPar(d) ^ badPar);
    sendBit(1'b1);
    sendBit(1'b1);
  endtask

  task automatic expect_item(input logic [2:0] tags, input logic [7:0] d);
    expQ.push_back({tags, d});
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic pulseStatus();
    statusRd = 1'b1; @(negedge clk); statusRd = 1'b0; @(negedge clk);
  endtask

  task automatic pulsePop();
    fifoRd = 1'b1; @(negedge clk); fifoRd = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R8 / R9: reset state of the status byte
    check(status == 8'h60, "R1 R8 R9 reset status", status, 8'h60);
    check(rxData == 8'h00, "R1 reset data", rxData, 8'h00);

    // R1: plain frames without parity, order and LSB-first
    curReq = "R1 plain frames";
    monOn = 1'b1;
    expect_item(3'b000, 8'hA5); sendFrame(8'hA5, 1'b0);
    expect_item(3'b000, 8'h3C); sendFrame(8'h3C, 1'b0);
    expect_item(3'b000, 8'hFF); sendFrame(8'hFF, 1'b0);
    expect_item(3'b000, 8'h01); sendFrame(8'h01, 1'b0);
    drain();

    // R3: even and odd parity, correct and wrong
    curReq = "R3 parity";
    parityEn = 1'b1; parityOdd = 1'b0;
    expect_item(3'b000, 8'h96); sendFrame(8'h96, 1'b0);
    expect_item(3'b001, 8'h07); sendFrame(8'h07, 1'b1);
    parityOdd = 1'b1;
    expect_item(3'b000, 8'h5E); sendFrame(8'h5E, 1'b0);
    expect_item(3'b001, 8'h80); sendFrame(8'h80, 1'b1);
    drain();
    parityEn = 1'b0; parityOdd = 1'b0;

    // R4 / R5: low stop bit, next data follows with no start bit
    curReq = "R4 R5 framing resync";
    expect_item(3'b010, 8'h5A);
    expect_item(3'b000, 8'hC3);
    sendBit(1'b0); sendData(8'h5A); sendBit(1'b0);
    sendData(8'hC3); sendBit(1'b1); sendBit(1'b1);
    drain();

    // R6: break, one zero entry, no more until the line is high
    curReq = "R6 break";
    expect_item(3'b110, 8'h00);
    repeat (16) sendBit(1'b0);
    sendBit(1'b1); sendBit(1'b1);
    expect_item(3'b000, 8'h81); sendFrame(8'h81, 1'b0);
    drain();

    // R7 / R8: head tags, not those of the latest character
    monOn = 1'b0;
    repeat (4) @(negedge clk);
    parityEn = 1'b1;
    sendFrame(8'h22, 1'b0);
    sendFrame(8'h11, 1'b1);
    check(status[2] == 1'b0, "R7 good head hides later parity error", status[2], 1'b0);
    check(rxData == 8'h22, "R7 head data", rxData, 8'h22);
    pulsePop();
    check(status[2] == 1'b1, "R7 new head shows parity error", status[2], 1'b1);
    pulseStatus();
    check(status[2] == 1'b0, "R8 status read clears parity tag", status[2], 1'b0);
    check({status[0], rxData} == {1'b1, 8'h11}, "R8 head kept after status read", {status[0], rxData}, {1'b1, 8'h11});
    pulsePop();
    check(status[0] == 1'b0, "R1 empty after last pop", status[0], 1'b0);
    parityEn = 1'b0;

    // R2: seventeen characters into a queue of sixteen
    for (int i = 0; i < 17; i++) sendFrame(8'(i * 7 + 1), 1'b0);
    check(status[1:0] == 2'b11, "R2 overrun set with data ready", status[1:0], 2'b11);
    check(rxData == 8'h01, "R2 head unchanged", rxData, 8'h01);
    pulseStatus();
    check(status[1] == 1'b0, "R8 status read clears overrun", status[1], 1'b0);
    curReq = "R2 queue kept, last dropped";
    for (int i = 0; i < 16; i++) expect_item(3'b000, 8'(i * 7 + 1));
    monOn = 1'b1;
    drain();
    check(status[0] == 1'b0, "R2 seventeenth character dropped", status[0], 1'b0);
    monOn = 1'b0;

    // R9: transmitter flags
    thrEmpty = 1'b0; tsrEmpty = 1'b1;
    repeat (2) @(negedge clk);
    check(status[7:5] == 3'b000, "R9 holding busy", status[7:5], 3'b000);
    thrEmpty = 1'b1; tsrEmpty = 1'b0;
    repeat (2) @(negedge clk);
    check(status[7:5] == 3'b001, "R9 shifter busy", status[7:5], 3'b001);
    tsrEmpty = 1'b1;
    repeat (2) @(negedge clk);
    check(status[7:5] == 3'b011, "R9 both empty", status[7:5], 3'b011);

    check(expQ.size() == 0, "R1 scoreboard empty", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule